// File: doc/BRIEF.md
# Randomized Sequential Reservation Controller

This block is the central sequencer of an N-port input-queued crossbar. Every switching interval it shuffles the list of input ports into a fresh random order. It then strobes the ports one at a time over a private line per port. The strobed port reads the shared availability vector and answers with a done flag and the one-hot output it wants. Because only one port is ever strobed, two ports can never claim the same output.

The controller owns the availability vector. At the start of each round it sets every bit to one, meaning that every output is free. It clears a bit only when the strobed port makes a legal claim. A port that stays silent for too long is skipped and keeps no output.

At the end of each fixed-length interval, the controller publishes the full input-to-output map to the crossbar with a one-cycle valid pulse. In that same cycle it starts the reservation round for the next interval. The following round therefore overlaps the transmission of the published map, and no cycles are lost between intervals.

Top module: `seqres_ctrl`

## Requirements
- R1: While reset is held, `port_strobe`, `cfg_valid` and `cfg_map` are zero and `avail_bus` is all ones.
- R2: At most one bit of `port_strobe` is high in any cycle.
- R3: In every round each of the N ports is strobed exactly once.
- R4: A strobed port's line stays high until the port raises its own `port_done` bit. The strobe then moves on at the next edge. A `port_done` bit from a port that is not being strobed has no effect on `avail_bus` or on the published map.
- R5: `avail_bus` is all ones when the first strobe of a round appears. After a legal claim by the strobed port, the claimed bit is zero from the next cycle on. No other bit changes during the round.
- R6: A claim is legal only if the port's `port_pick` slice has exactly one bit set and that bit is currently one in `avail_bus`. A slice of zero, a slice with two or more bits set, or a claim on an output already reserved is recorded as no output and leaves `avail_bus` unchanged.
- R7: A port that gives no `port_done` keeps its strobe for exactly TIMEOUT_CYC cycles. It is then recorded as holding no output, and the next port is strobed.
- R8: `cfg_valid` is high for a single cycle once every SLOT_CYC*SLOTS_PER_IV cycles. The first pulse comes that many clock edges after reset is released. `cfg_map[i*N+:N]` holds the one-hot output that input i reserved in the round just finished, or zero if it reserved none. `cfg_map` does not change between pulses.
- R9: The next round starts in the same cycle as the `cfg_valid` pulse. Its first strobe appears exactly N_PORTS cycles after that pulse, or N_PORTS cycles after reset for the first round.
- R10: The strobe order is drawn again for each interval, so successive rounds do not all use the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_strobe | output | N_PORTS | One-hot grant line, one bit per input port |
| port_done | input | N_PORTS | Per-port completion flag, sampled only for the strobed port |
| port_pick | input | N_PORTS*N_PORTS | Per-port one-hot claimed output; slice i belongs to port i |
| avail_bus | output | N_PORTS | Shared free-output vector, 1 means free |
| cfg_map | output | N_PORTS*N_PORTS | Published map; slice i is the output granted to input i |
| cfg_valid | output | 1 | One-cycle pulse that marks a new `cfg_map` |

## Verification
The map publication and the restart of the next round fall in the same cycle. The bench provokes this at every interval. At each `cfg_valid` pulse it compares the map against a scoreboard entry that the port model pushed when the previous round ended. It then requires the next round to reset `avail_bus` to all ones and raise its first strobe exactly N_PORTS cycles later. A second overlap is also tested: in some rounds, non-strobed ports assert `done` with legal-looking claims in the same cycle that the strobed port answers, and the bench checks that only the strobed claim reaches `avail_bus` and the map.

// File: rtl/seqres_pkg.sv
package seqres_pkg;

   typedef enum logic [1:0] {
      ST_INIT = 2'd0,
      ST_SHUF = 2'd1,
      ST_RUN  = 2'd2,
      ST_HOLD = 2'd3
   } round_st_e;

   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/seqres_lfsr.sv
module seqres_lfsr #(
   parameter int unsigned     WIDTH = 16,
   parameter logic [WIDTH-1:0] SEED = 'hACE1
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [WIDTH-1:0] state
);

   logic [WIDTH-1:0] taps;

   generate
      if (WIDTH == 8) begin : g_w8
         assign taps = 8'hB8;
      end else if (WIDTH == 16) begin : g_w16
         assign taps = 16'hB400;
      end else if (WIDTH == 32) begin : g_w32
         assign taps = 32'h8020_0003;
      end else begin : g_bad_width
         assign taps = '0;
         $error("seqres_lfsr: WIDTH must be 8, 16 or 32");
      end
      if (SEED == '0) begin : g_bad_seed
         $error("seqres_lfsr: SEED must be nonzero");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= SEED;
      end else begin
         state <= (state >> 1) ^ (state[0] ? taps : '0);
      end
   end

   // R10: the random source never locks up at zero
   p_lfsr_live_r10: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0);

endmodule

// File: rtl/seqres_shuffle.sv
module seqres_shuffle
   import seqres_pkg::*;
#(
   parameter int unsigned N_PORTS = 4,
   parameter int unsigned RND_W   = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                start,
   input  logic [RND_W-1:0]                    rnd,
   output logic [N_PORTS*idx_w(N_PORTS)-1:0]   perm_flat,
   output logic                                active,
   output logic                                last
);

   localparam int unsigned IW = idx_w(N_PORTS);
   localparam int unsigned PW = RND_W + IW + 1;

   generate
      if (N_PORTS < 2) begin : g_bad_n
         $error("seqres_shuffle: N_PORTS must be at least 2");
      end
      if (RND_W < IW + 2) begin : g_bad_rnd
         $error("seqres_shuffle: RND_W too small for an even index draw");
      end
   endgenerate

   logic [IW-1:0]      perm [N_PORTS];
   logic [IW-1:0]      cur_i;
   logic [IW-1:0]      pick_j;
   logic [PW-1:0]      prod;
   logic [N_PORTS-1:0] seen;

   // scaled draw: j = floor(rnd * (i+1) / 2^RND_W), always in 0..i
   always_comb begin
      prod   = {{(IW+1){1'b0}}, rnd} * {{RND_W{1'b0}}, ({1'b0, cur_i} + 1'b1)};
      pick_j = prod[RND_W +: IW];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < N_PORTS; k++) perm[k] <= IW'(k);
         cur_i  <= '0;
         active <= 1'b0;
      end else if (start) begin
         for (int k = 0; k < N_PORTS; k++) perm[k] <= IW'(k);
         cur_i  <= IW'(N_PORTS - 1);
         active <= 1'b1;
      end else if (active) begin
         perm[cur_i]  <= perm[pick_j];
         perm[pick_j] <= perm[cur_i];
         cur_i        <= cur_i - 1'b1;
         if (cur_i == IW'(1)) active <= 1'b0;
      end
   end

   assign last = active && (cur_i == IW'(1));

   genvar g;
   generate
      for (g = 0; g < N_PORTS; g++) begin : g_flat
         assign perm_flat[g*IW +: IW] = perm[g];
      end
   endgenerate

   always_comb begin
      seen = '0;
      for (int k = 0; k < N_PORTS; k++) seen = seen | (N_PORTS'(1) << perm[k]);
   end

   // R3: the index array is a permutation of all ports at every edge
   p_perm_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
      seen == '1);

   // R3: a shuffle pass never draws an index beyond the current slot
   p_draw_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (pick_j <= cur_i));

endmodule

// File: rtl/seqres_seq.sv
module seqres_seq
   import seqres_pkg::*;
#(
   parameter int unsigned N_PORTS     = 4,
   parameter int unsigned TIMEOUT_CYC = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              clear,
   input  logic                              run,
   input  logic [N_PORTS*idx_w(N_PORTS)-1:0] perm_flat,
   input  logic [N_PORTS-1:0]                port_done,
   input  logic [N_PORTS*N_PORTS-1:0]        port_pick,
   output logic [N_PORTS-1:0]                port_strobe,
   output logic [N_PORTS-1:0]                avail,
   output logic [N_PORTS*N_PORTS-1:0]        rec_flat,
   output logic                              fin
);

   localparam int unsigned IW = idx_w(N_PORTS);
   localparam int unsigned CW = idx_w(TIMEOUT_CYC + 1);

   generate
      if (TIMEOUT_CYC < 1) begin : g_bad_to
         $error("seqres_seq: TIMEOUT_CYC must be at least 1");
      end
   endgenerate

   logic [IW-1:0]      pos;
   logic [CW-1:0]      wcnt;
   logic [N_PORTS-1:0] avail_q;
   logic [N_PORTS-1:0] rec [N_PORTS];

   logic [IW-1:0]      cur;
   logic [N_PORTS-1:0] cur_pick;
   logic               cur_done;
   logic               expired;
   logic               step;
   logic               legal;
   logic               last_pos;

   always_comb begin
      cur      = perm_flat[pos*IW +: IW];
      cur_pick = port_pick[cur*N_PORTS +: N_PORTS];
      cur_done = port_done[cur];
      expired  = (wcnt == CW'(TIMEOUT_CYC - 1));
      step     = run && (cur_done || expired);
      legal    = cur_done && (cur_pick != '0)
                 && ((cur_pick & (cur_pick - 1'b1)) == '0)
                 && ((cur_pick & avail_q) != '0);
      last_pos = (pos == IW'(N_PORTS - 1));
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
         pos     <= '0;
         wcnt    <= '0;
         avail_q <= '1;
         for (int k = 0; k < N_PORTS; k++) rec[k] <= '0;
      end else if (run) begin
         if (step) begin
            rec[cur] <= legal ? cur_pick : '0;
            if (legal) avail_q <= avail_q & ~cur_pick;
            if (!last_pos) pos <= pos + 1'b1;
            wcnt <= '0;
         end else begin
            wcnt <= wcnt + 1'b1;
         end
      end
   end

   assign port_strobe = run ? (N_PORTS'(1) << cur) : '0;
   assign avail       = avail_q;
   assign fin         = step && last_pos;

   genvar g;
   generate
      for (g = 0; g < N_PORTS; g++) begin : g_rec
         assign rec_flat[g*N_PORTS +: N_PORTS] = rec[g];
      end
   endgenerate

   // R2: never more than one port holds the grant line
   p_single_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(port_strobe));

   // R4: grant is held while the port neither answers nor times out
   p_grant_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !step) |=> $stable(port_strobe));

   // R5: within a round bits of the free vector only fall
   p_free_falls_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !clear |=> ((avail_q & ~$past(avail_q)) == '0));

   // R6: a rejected answer leaves the free vector untouched
   p_reject_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !legal) |=> $stable(avail_q));

   // R7: the wait counter never passes the timeout limit
   p_wait_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wcnt < CW'(TIMEOUT_CYC));

endmodule

// File: rtl/seqres_ctrl.sv
module seqres_ctrl
   import seqres_pkg::*;
#(
   parameter int unsigned N_PORTS      = 4,
   parameter int unsigned TIMEOUT_CYC  = 8,
   parameter int unsigned SLOT_CYC     = 16,
   parameter int unsigned SLOTS_PER_IV = 4,
   parameter int unsigned LFSR_W       = 16,
   parameter int unsigned LFSR_SEED    = 32'h0000_ACE1,
   parameter int unsigned RND_W        = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   output logic [N_PORTS-1:0]           port_strobe,
   input  logic [N_PORTS-1:0]           port_done,
   input  logic [N_PORTS*N_PORTS-1:0]   port_pick,
   output logic [N_PORTS-1:0]           avail_bus,
   output logic [N_PORTS*N_PORTS-1:0]   cfg_map,
   output logic                         cfg_valid
);

   localparam int unsigned IW        = idx_w(N_PORTS);
   localparam int unsigned IV_CYC    = SLOT_CYC * SLOTS_PER_IV;
   localparam int unsigned ICW       = idx_w(IV_CYC);
   localparam int unsigned ROUND_MAX = 1 + (N_PORTS - 1) + N_PORTS * TIMEOUT_CYC + 1;

   generate
      if (IV_CYC < ROUND_MAX) begin : g_bad_iv
         $error("seqres_ctrl: interval shorter than the longest reservation round");
      end
      if (LFSR_W < RND_W) begin : g_bad_rw
         $error("seqres_ctrl: LFSR_W must cover RND_W");
      end
   endgenerate

   logic [ICW-1:0]              ic;
   logic                        bound;
   round_st_e                   st;
   logic [LFSR_W-1:0]           lfsr_q;
   logic [N_PORTS*IW-1:0]       perm_flat;
   logic                        shuf_active;
   logic                        shuf_last;
   logic                        seq_fin;
   logic [N_PORTS*N_PORTS-1:0]  rec_flat;

   assign bound = (ic == ICW'(IV_CYC - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || bound) ic <= '0;
      else                 ic <= ic + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st <= ST_INIT;
      end else if (bound) begin
         st <= ST_INIT;
      end else begin
         unique case (st)
            ST_INIT: st <= ST_SHUF;
            ST_SHUF: if (shuf_last) st <= ST_RUN;
            ST_RUN:  if (seq_fin)   st <= ST_HOLD;
            default: st <= ST_HOLD;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_map   <= '0;
         cfg_valid <= 1'b0;
      end else begin
         cfg_valid <= bound;
         if (bound) cfg_map <= rec_flat;
      end
   end

   seqres_lfsr #(
      .WIDTH (LFSR_W),
      .SEED  (LFSR_W'(LFSR_SEED))
   ) u_lfsr (
      .clk   (clk),
      .rst_n (rst_n),
      .state (lfsr_q)
   );

   seqres_shuffle #(
      .N_PORTS (N_PORTS),
      .RND_W   (RND_W)
   ) u_shuffle (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (st == ST_INIT),
      .rnd       (lfsr_q[RND_W-1:0]),
      .perm_flat (perm_flat),
      .active    (shuf_active),
      .last      (shuf_last)
   );

   seqres_seq #(
      .N_PORTS     (N_PORTS),
      .TIMEOUT_CYC (TIMEOUT_CYC)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .clear       (st == ST_INIT),
      .run         (st == ST_RUN),
      .perm_flat   (perm_flat),
      .port_done   (port_done),
      .port_pick   (port_pick),
      .port_strobe (port_strobe),
      .avail       (avail_bus),
      .rec_flat    (rec_flat),
      .fin         (seq_fin)
   );

   // R8: the publish pulse lasts exactly one cycle
   p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_valid |=> !cfg_valid);

   // R8: the published map is frozen between pulses
   p_map_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_valid |-> $stable(cfg_map));

   // R9: every round has ended before the interval closes
   p_round_fits_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bound |-> (st == ST_HOLD));

   // R9: the shuffler is idle whenever ports are being strobed
   p_shuffle_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (port_strobe != '0) |-> !shuf_active);

endmodule

// File: tb/seqres_ctrl_bench.sv
module seqres_ctrl_bench;

   localparam int N    = 4;
   localparam int TO   = 8;
   localparam int SLOT = 16;
   localparam int SLTS = 4;
   localparam int IV   = SLOT * SLTS;
   localparam int ROUNDS = 10;
   localparam int WATCHDOG = 5000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [N-1:0]   strobe;
   logic [N-1:0]   done;
   logic [N*N-1:0] pick;
   logic [N-1:0]   avail;
   logic [N*N-1:0] cfg_map;
   logic           cfg_valid;

   seqres_ctrl #(
      .N_PORTS      (N),
      .TIMEOUT_CYC  (TO),
      .SLOT_CYC     (SLOT),
      .SLOTS_PER_IV (SLTS)
   ) u_seqres_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .port_strobe (strobe),
      .port_done   (done),
      .port_pick   (pick),
      .avail_bus   (avail),
      .cfg_map     (cfg_map),
      .cfg_valid   (cfg_valid)
   );

   int errors = 0;
   int checks = 0;
   int cyc = 0;

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   // port model state
   int             mode [N];   // 0 normal, 1 silent, 2 zero pick, 3 reserved pick, 4 two-bit pick
   int             lat  [N];
   bit             stray;
   int             round_no = 0;
   logic [N-1:0]   prev_strobe = '0;
   int             ep_cnt = 0;
   int             ep_len = 0;
   int             cur_p = 0;
   bit             responded = 0;
   logic [N-1:0]   seen = '0;
   logic [N*N-1:0] exp_map = '0;
   logic [N-1:0]   exp_avail = '1;
   bit             tracking = 0;
   bit             reject_pending = 0;
   int             order_code = 0;
   int             orders [$];
   logic [N*N-1:0] sbq [$];
   logic [N*N-1:0] last_cfg = '0;
   int             last_cv = 0;
   int             cv_cnt = 0;
   bit             prev_cv = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [N-1:0] first_free(input logic [N-1:0] av, input int start);
      logic [N-1:0] r;
      r = '0;
      for (int k = 0; k < N; k++) begin
         if (av[(start + k) % N] && r == '0) r[(start + k) % N] = 1'b1;
      end
      return r;
   endfunction

   function automatic int idx_of(input logic [N-1:0] v);
      int r;
      r = 0;
      for (int k = 0; k < N; k++) if (v[k]) r = k;
      return r;
   endfunction

   task automatic setup_round(input int r);
      for (int p = 0; p < N; p++) begin
         mode[p] = 0;
         lat[p]  = (p + r) % 3;
      end
      stray = 0;
      case (r)
         2: mode[1] = 1;
         3: begin mode[2] = 2; mode[3] = 3; end
         4: begin mode[0] = 4; stray = 1; end
         5: for (int p = 0; p < N; p++) mode[p] = 1;
         6: begin
            mode[3] = 3; mode[0] = 4; stray = 1;
            for (int p = 0; p < N; p++) lat[p] = 0;
         end
         default: stray = (r >= 7) && (r % 2 == 1);
      endcase
   endtask

   task automatic end_episode();
      if (mode[cur_p] == 1)
         chk(ep_len == TO, "R7", "silent port grant length", 64'(ep_len), 64'(TO));
      else
         chk(ep_len == lat[cur_p] + 1, "R4", "grant held until done", 64'(ep_len), 64'(lat[cur_p] + 1));
   endtask

   // driver: models the ports and pushes the expected map into the scoreboard
   task automatic drive_ports();
      logic [N-1:0] pv;
      logic [N-1:0] ffree;
      bit           legal;
      int           p;
      done = '0;
      pick = '0;
      if (tracking)
         chk(avail == exp_avail, reject_pending ? "R6" : "R5", "free vector", 64'(avail), 64'(exp_avail));
      reject_pending = 0;
      if (strobe != '0) begin
         chk($countones(strobe) == 1, "R2", "single grant", 64'(strobe), 64'(1));
         p = idx_of(strobe);
         if (strobe != prev_strobe) begin
            if (prev_strobe != '0) end_episode();
            ep_cnt++;
            if (ep_cnt == 1) begin
               chk(cyc - last_cv == N, "R9", "first grant delay", 64'(cyc - last_cv), 64'(N));
               chk(avail == '1, "R5", "free vector at round start", 64'(avail), 64'('1));
               exp_avail  = '1;
               exp_map    = '0;
               tracking   = 1;
               seen       = '0;
               order_code = 0;
            end
            chk(!seen[p], "R3", "port granted twice", 64'(p), 64'(0));
            seen[p]    = 1'b1;
            order_code = order_code * N + p;
            ep_len     = 0;
            responded  = 0;
            cur_p      = p;
         end
         ep_len++;
         if (!responded && mode[p] != 1 && ep_len - 1 == lat[p]) begin
            ffree = first_free(avail, (p + round_no) % N);
            case (mode[p])
               2: pv = '0;
               3: pv = (~avail != '0) ? first_free(~avail, 0) : ffree;
               4: pv = ($countones(avail) >= 2)
                       ? (first_free(avail, 0) | first_free(avail & ~first_free(avail, 0), 0))
                       : ffree;
               default: pv = ffree;
            endcase
            done[p]        = 1'b1;
            pick[p*N +: N] = pv;
            responded      = 1;
            legal = ($countones(pv) == 1) && ((pv & exp_avail) != '0);
            exp_map[p*N +: N] = legal ? pv : '0;
            if (legal) exp_avail = exp_avail & ~pv;
            else       reject_pending = 1;
         end
         if (stray) begin
            for (int q = 0; q < N; q++) begin
               if (q != p) begin
                  done[q]        = 1'b1;
                  pick[q*N +: N] = first_free(avail, q);
               end
            end
         end
      end else if (prev_strobe != '0) begin
         end_episode();
         chk(ep_cnt == N, "R3", "grants per round", 64'(ep_cnt), 64'(N));
         chk(seen == '1, "R3", "ports covered", 64'(seen), 64'('1));
         sbq.push_back(exp_map);
         orders.push_back(order_code);
         ep_cnt = 0;
      end
      prev_strobe = strobe;
   endtask

   // monitor: pops the scoreboard when the design publishes a map
   task automatic watch_cfg();
      logic [N*N-1:0] want;
      if (cfg_valid) begin
         chk(!prev_cv, "R8", "pulse width", 64'(1), 64'(0));
         chk(cyc - last_cv == IV, "R8", "pulse period", 64'(cyc - last_cv), 64'(IV));
         last_cv = cyc;
         cv_cnt++;
         if (sbq.size() == 0) begin
            chk(0, "R8", "map published without a finished round", 64'(cfg_map), 64'(0));
         end else begin
            want = sbq.pop_front();
            chk(cfg_map == want, "R8", "published map", 64'(cfg_map), 64'(want));
         end
         last_cfg = cfg_map;
         tracking = 0;
         round_no++;
         setup_round(round_no);
      end else begin
         chk(cfg_map == last_cfg, "R8", "map frozen between pulses", 64'(cfg_map), 64'(last_cfg));
      end
      prev_cv = cfg_valid;
   endtask

   initial begin
      int distinct;
      done = '0;
      pick = '0;
      setup_round(0);
      repeat (3) @(negedge clk);
      chk(strobe == '0, "R1", "grant lines in reset", 64'(strobe), 64'(0));
      chk(cfg_valid == 1'b0, "R1", "publish pulse in reset", 64'(cfg_valid), 64'(0));
      chk(cfg_map == '0, "R1", "map in reset", 64'(cfg_map), 64'(0));
      chk(avail == '1, "R1", "free vector in reset", 64'(avail), 64'('1));
      rst_n = 1'b1;
      forever begin
         @(negedge clk);
         watch_cfg();
         drive_ports();
         if (cv_cnt >= ROUNDS) break;
         if (cyc > WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, WATCHDOG);
            break;
         end
      end
      distinct = 0;
      for (int a = 0; a < orders.size(); a++) begin
         bit fresh;
         fresh = 1;
         for (int b = 0; b < a; b++) if (orders[b] == orders[a]) fresh = 0;
         if (fresh) distinct++;
      end
      chk(distinct > 1, "R10", "distinct grant orders", 64'(distinct), 64'(2));
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule